// File: doc/BRIEF.md
# Clock Configuration Register Slave on a Two-Wire Serial Bus

This block is the control port of a two-output clock generator. A host reaches it over a two-wire serial bus (I2C, standard mode up to 100 kbit/s). The block oversamples SCL and SDA with a fast system clock and pulls SDA low through an open-drain enable. It holds two 8-bit configuration registers. These drive three control pins: the enable of the first PLL, the enable of the second PLL, and the frequency select of the second output (72 MHz or 48 MHz).

Every bus transfer uses a block protocol. After the device address, the host sends a start index. A write then carries an explicit byte count ahead of the data. A read is entered with a repeated start. The device first returns how many bytes follow and then returns the register contents from the start index onward. A malformed index or count is refused with a NACK, and the rest of that transfer leaves the registers alone.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset, register 0 holds 0x57 and register 1 holds 0x00. So `pll1_en`=1, `pll2_en`=1 and `out2_sel48`=0.
- R2: The address bytes 0xD4 (write) and 0xD5 (read) are acknowledged (SDA low in the ninth clock). Any other address byte is not acknowledged, and the slave stays off the bus until the next start.
- R3: A write runs as follows: 0xD4, then start index n, then byte count x, then x data bytes. The slave acknowledges every byte, and the data lands in registers n to n+x-1.
- R4: Bit 0 of register 0 drives `pll1_en` and bit 1 drives `pll2_en`. Writing 0x55 to register 0 clears `pll2_en` and leaves `pll1_en` at 1.
- R5: Bit 7 of register 1 drives `out2_sel48` (0 selects 72 MHz, 1 selects 48 MHz). The other bits of register 1 read back as written.
- R6: A read runs as follows: 0xD4, then index n, then a repeated start, then 0xD5. The slave then sends 2-n, followed by registers n and onward, each byte MSB first.
- R7: When the host NACKs a read byte, the slave releases SDA (`sda_oe`=0) and sends nothing more.
- R8: A start index above 1 is not acknowledged, and later bytes of that transfer are not acknowledged and change nothing.
- R9: A byte count of 0, a count above 2, or a count with n+x>2 is not acknowledged, and no register changes.
- R10: A data byte beyond the announced count is not acknowledged and is not written anywhere.
- R11: Each data byte takes effect at the acknowledge that follows it, before the next byte starts. A two-byte write therefore changes register n before register n+1 arrives.
- R12: A pulse on SCL or SDA that lasts for fewer than 3 consecutive synchronized samples is ignored. It creates no clock edge, start or stop.
- R13: The slave changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| pll1_en | output | 1 | Enable of the first-output PLL (register 0 bit 0) |
| pll2_en | output | 1 | Enable of the second-output PLL (register 0 bit 1) |
| out2_sel48 | output | 1 | Second-output frequency select, 1 = 48 MHz (register 1 bit 7) |

## Verification
The bench drives a start index of 2, and counts of 0, 3 and 1+2. A slave that checked only the count range would acknowledge some of these and then corrupt a register or write past the end. A surplus data byte after a correct count is also sent; a slave that kept auto-incrementing would acknowledge it. A two-byte write is probed between its bytes, which catches a slave that buffers data until stop. One transfer is sent with single-sample spikes on both lines while SCL is high and low; a slave without the filter would see a false stop or an extra bit and lose the byte. Reads from both indices check the leading count byte and the NACK-driven release of SDA.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int NREG  = 2;
    localparam int PTR_W = $clog2(NREG + 1);
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    localparam logic [6:0] DEV_ADDR = 7'h6A;   // 0xD4 write, 0xD5 read

    localparam int DEF_SYNC_STAGES = 2;
    localparam int DEF_FILT_LEN    = 3;

    localparam int PLL1_BIT  = 0;   // register 0
    localparam int PLL2_BIT  = 1;   // register 0
    localparam int SEL48_BIT = 7;   // register 1

    typedef enum logic [2:0] {
        R_IDLE,
        R_ADDR,
        R_INDEX,
        R_COUNT,
        R_WDATA,
        R_TX
    } role_e;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic [7:0]       data;
    } wr_req_t;

    function automatic logic [7:0] reg_reset(input int i);
        return (i == 0) ? 8'h57 : 8'h00;
    endfunction

    function automatic logic count_ok(input logic [PTR_W-1:0] start, input logic [7:0] cnt);
        return (cnt != 8'd0) && (int'(cnt) <= NREG) && (int'(start) + int'(cnt) <= NREG);
    endfunction

endpackage

// File: rtl/clkcfg_line_filter.sv
module clkcfg_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= {SYNC_STAGES{1'b1}};
            hist_q <= {FILT_LEN{1'b1}};
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            if (&hist_q)
                dout <= 1'b1;
            else if (~|hist_q)
                dout <= 1'b0;
        end
    end
endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
    import clkcfg_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  wr_req_t                   wr,
    output logic [NREG-1:0][7:0]      regs_q
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= reg_reset(g);
            else if (wr.en && (int'(wr.idx) == g))
                regs_q[g] <= wr.data;
        end
    end
endmodule

// File: rtl/clkcfg_engine.sv
module clkcfg_engine
    import clkcfg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_f,
    input  logic                  sda_f,
    input  logic [NREG-1:0][7:0]  regs_q,
    output wr_req_t               wr,
    output logic                  sda_oe
);
    role_e            role, next_role;
    logic [3:0]       bitcnt;
    logic             ack_slot;
    logic             m_ack;
    logic [7:0]       rx_sh;
    logic [7:0]       tx_byte;
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] remain;
    logic             scl_q, sda_q;

    logic start_ev, stop_ev, scl_rise, scl_fall;
    logic accept, byte_end;
    logic [7:0] cnt_byte, next_tx;

    assign start_ev = scl_f && scl_q && sda_q && !sda_f;
    assign stop_ev  = scl_f && scl_q && !sda_q && sda_f;
    assign scl_rise = scl_f && !scl_q;
    assign scl_fall = !scl_f && scl_q;

    assign cnt_byte = 8'(NREG - int'(ptr));
    assign next_tx  = (int'(ptr) < NREG) ? regs_q[ptr[IDX_W-1:0]] : 8'hFF;

    always_comb begin
        case (role)
            R_ADDR:  accept = (rx_sh[7:1] == DEV_ADDR);
            R_INDEX: accept = (int'(rx_sh) < NREG);
            R_COUNT: accept = count_ok(ptr, rx_sh);
            R_WDATA: accept = (remain != '0);
            default: accept = 1'b0;
        endcase
        byte_end = scl_fall && !start_ev && !stop_ev && !ack_slot && (bitcnt == 4'd8)
                   && (role != R_IDLE) && (role != R_TX);
        wr.en   = byte_end && (role == R_WDATA) && accept;
        wr.idx  = ptr[IDX_W-1:0];
        wr.data = rx_sh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            role      <= R_IDLE;
            next_role <= R_IDLE;
            bitcnt    <= '0;
            ack_slot  <= 1'b0;
            m_ack     <= 1'b0;
            rx_sh     <= '0;
            tx_byte   <= '0;
            ptr       <= '0;
            remain    <= '0;
            sda_oe    <= 1'b0;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
            if (start_ev) begin
                role     <= R_ADDR;
                bitcnt   <= '0;
                ack_slot <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (stop_ev) begin
                role     <= R_IDLE;
                ack_slot <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (role != R_IDLE) begin
                if (scl_rise) begin
                    if (!ack_slot) begin
                        rx_sh <= {rx_sh[6:0], sda_f};
                        if (bitcnt != 4'd8)
                            bitcnt <= bitcnt + 4'd1;
                    end else begin
                        m_ack <= !sda_f;
                    end
                end else if (scl_fall) begin
                    if (ack_slot) begin
                        ack_slot <= 1'b0;
                        bitcnt   <= '0;
                        if (role == R_TX) begin
                            if (m_ack) begin
                                tx_byte <= next_tx;
                                sda_oe  <= !next_tx[7];
                                if (int'(ptr) != NREG)
                                    ptr <= ptr + PTR_W'(1);
                            end else begin
                                role   <= R_IDLE;
                                sda_oe <= 1'b0;
                            end
                        end else begin
                            role   <= next_role;
                            sda_oe <= 1'b0;
                            if (next_role == R_TX) begin
                                tx_byte <= cnt_byte;
                                sda_oe  <= !cnt_byte[7];
                            end
                        end
                    end else if (bitcnt == 4'd8) begin
                        if (role == R_TX) begin
                            ack_slot <= 1'b1;
                            sda_oe   <= 1'b0;
                        end else if (accept) begin
                            ack_slot <= 1'b1;
                            sda_oe   <= 1'b1;
                            case (role)
                                R_ADDR:  next_role <= rx_sh[0] ? R_TX : R_INDEX;
                                R_INDEX: begin
                                    ptr       <= rx_sh[PTR_W-1:0];
                                    next_role <= R_COUNT;
                                end
                                R_COUNT: begin
                                    remain    <= rx_sh[PTR_W-1:0];
                                    next_role <= R_WDATA;
                                end
                                default: begin
                                    ptr       <= ptr + PTR_W'(1);
                                    remain    <= remain - PTR_W'(1);
                                    next_role <= R_WDATA;
                                end
                            endcase
                        end else begin
                            role   <= R_IDLE;
                            sda_oe <= 1'b0;
                        end
                    end else if (role == R_TX) begin
                        sda_oe <= !tx_byte[3'(4'd7 - bitcnt)];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
    import clkcfg_pkg::*;
#(
    parameter int SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int FILT_LEN    = DEF_FILT_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic pll1_en,
    output logic pll2_en,
    output logic out2_sel48
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, filt_lines;
    wr_req_t           wr;
    logic [NREG-1:0][7:0] regs_q;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        clkcfg_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
        ) u_filt (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_lines[g]),
            .dout (filt_lines[g])
        );
    end

    clkcfg_engine u_engine (
        .clk    (clk),
        .rst    (rst),
        .scl_f  (filt_lines[0]),
        .sda_f  (filt_lines[1]),
        .regs_q (regs_q),
        .wr     (wr),
        .sda_oe (sda_oe)
    );

    clkcfg_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .regs_q (regs_q)
    );

    assign pll1_en    = regs_q[0][PLL1_BIT];
    assign pll2_en    = regs_q[0][PLL2_BIT];
    assign out2_sel48 = regs_q[1][SEL48_BIT];
endmodule

// File: rtl/clkcfg_i2c_chk.sv
module clkcfg_i2c_chk (
    input logic clk,
    input logic rst,
    input logic scl_i,
    input logic sda_oe,
    input logic pll1_en,
    input logic pll2_en,
    input logic out2_sel48
);
    // R1: reset leaves both PLLs enabled and the 72 MHz select
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (pll1_en && pll2_en && !out2_sel48));

    // R13: the open-drain enable moves only in the SCL low phase
    assert_oe_scl_low_R13: assert property (@(posedge clk) disable iff (rst)
        $changed(sda_oe) |-> !scl_i);

    // R11: register 0 changes only while the slave drives its acknowledge
    assert_pll2_commit_ack_R11: assert property (@(posedge clk) disable iff (rst)
        $changed(pll2_en) |-> sda_oe);

    // R4: the first PLL enable also changes only with an acknowledge
    assert_pll1_commit_ack_R4: assert property (@(posedge clk) disable iff (rst)
        $changed(pll1_en) |-> sda_oe);

    // R5: the frequency select changes only with an acknowledge
    assert_sel48_commit_ack_R5: assert property (@(posedge clk) disable iff (rst)
        $changed(out2_sel48) |-> sda_oe);
endmodule

bind clkcfg_i2c_slave clkcfg_i2c_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_oe     (sda_oe),
    .pll1_en    (pll1_en),
    .pll2_en    (pll2_en),
    .out2_sel48 (out2_sel48)
);

// File: tb/tb_clkcfg_i2c_slave.sv
module tb_clkcfg_i2c_slave;
    localparam int Q = 16;   // system cycles per quarter bus period

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe, pll1_en, pll2_en, out2_sel48;

    always #2.5 clk = ~clk;   // 200 MHz

    assign sda_line = sda_m & ~sda_oe;

    clkcfg_i2c_slave dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .pll1_en    (pll1_en),
        .pll2_en    (pll2_en),
        .out2_sel48 (out2_sel48)
    );

    int checks = 0;
    int failures = 0;
    int oe_viol = 0;
    bit finished = 0;

    typedef struct {
        string req;
        string what;
        int    val;
    } exp_t;
    exp_t sb_q[$];

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_exp(string req, string what, int val);
        exp_t e;
        e.req = req; e.what = what; e.val = val;
        sb_q.push_back(e);
    endtask

    // monitor side: pops the oldest expectation and compares with what the bus showed
    task automatic observe(string what, int val);
        exp_t e;
        checks++;
        if (sb_q.size() == 0) begin
            failures++;
            $display("FAIL scoreboard %s actual=%0h expected=none", what, val);
        end else begin
            e = sb_q.pop_front();
            if (e.val !== val || e.what != what) begin
                failures++;
                $display("FAIL %s %s actual=%0h expected=%0h", e.req, e.what, val, e.val);
            end
        end
    endtask

    task automatic wait_q(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b1; wait_q(Q);
    endtask

    task automatic put_bit(logic b, bit glitch);
        sda_m = b; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        if (glitch) begin
            sda_m = ~b; wait_q(1);
            sda_m = b;  wait_q(Q - 1);
        end else begin
            wait_q(Q);
        end
        scl_m = 1'b0;
        if (glitch) begin
            wait_q(Q / 2);
            scl_m = 1'b1; wait_q(1);
            scl_m = 1'b0; wait_q(Q - Q / 2 - 1);
        end else begin
            wait_q(Q);
        end
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        b = sda_line; wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    // driver: pushes the expected acknowledge, then sends the byte
    task automatic send_byte(logic [7:0] v, bit exp_ack, string req, bit glitch = 0);
        logic a;
        push_exp(req, "ack", int'(exp_ack));
        for (int i = 7; i >= 0; i--) put_bit(v[i], glitch);
        get_bit(a);
        observe("ack", int'(!a));
    endtask

    task automatic recv_byte(logic [7:0] exp, bit host_ack, string req);
        logic [7:0] v;
        logic b;
        push_exp(req, "rdbyte", int'(exp));
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!host_ack, 0);
        observe("rdbyte", int'(v));
    endtask

    task automatic read_regs(logic [7:0] n, logic [7:0] r0, logic [7:0] r1, string req);
        bus_start();
        send_byte(8'hD4, 1, "R2");
        send_byte(n, 1, req);
        bus_start();
        send_byte(8'hD5, 1, "R2");
        recv_byte(8'd2 - n, 1, "R6");
        if (n == 8'd0) begin
            recv_byte(r0, 1, req);
            recv_byte(r1, 0, req);
        end else begin
            recv_byte(r1, 0, req);
        end
        chk("R7", "sda_oe after host nack", int'(sda_oe), 0);
        bus_stop();
    endtask

    task automatic write_hdr(logic [7:0] n, logic [7:0] x);
        bus_start();
        send_byte(8'hD4, 1, "R3");
        send_byte(n, 1, "R3");
        send_byte(x, 1, "R3");
    endtask

    // R13 monitor: slave enable must not move while the host holds SCL high
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst && scl_m && (sda_oe !== oe_prev)) oe_viol++;
        oe_prev <= sda_oe;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
    end

    initial begin
        wait_q(4);
        rst = 1'b0;
        wait_q(4);

        // R1 reset state
        chk("R1", "pll1_en", int'(pll1_en), 1);
        chk("R1", "pll2_en", int'(pll2_en), 1);
        chk("R1", "out2_sel48", int'(out2_sel48), 0);
        chk("R1", "sda_oe", int'(sda_oe), 0);

        // R6 full read from index 0, R7 host nack at the end
        read_regs(8'd0, 8'h57, 8'h00, "R6");

        // R4 partial power-down of the second PLL
        write_hdr(8'd0, 8'd1);
        send_byte(8'h55, 1, "R3");
        bus_stop();
        chk("R4", "pll2_en after 0x55", int'(pll2_en), 0);
        chk("R4", "pll1_en after 0x55", int'(pll1_en), 1);

        // R5 select 48 MHz
        write_hdr(8'd1, 8'd1);
        send_byte(8'h80, 1, "R3");
        bus_stop();
        chk("R5", "out2_sel48 after 0x80", int'(out2_sel48), 1);

        // R11 two-byte write, probe between the bytes
        write_hdr(8'd0, 8'd2);
        send_byte(8'h57, 1, "R3");
        chk("R11", "pll2_en before second byte", int'(pll2_en), 1);
        chk("R11", "sel48 untouched before second byte", int'(out2_sel48), 1);
        send_byte(8'h2C, 1, "R3");
        chk("R11", "sel48 after second byte", int'(out2_sel48), 0);
        bus_stop();

        // R5 readback of register 1 from index 1
        read_regs(8'd1, 8'h57, 8'h2C, "R5");

        // R2 foreign addresses
        bus_start();
        send_byte(8'hA0, 0, "R2");
        send_byte(8'h00, 0, "R2");
        bus_stop();
        bus_start();
        send_byte(8'hD6, 0, "R2");
        bus_stop();

        // R8 index out of range
        bus_start();
        send_byte(8'hD4, 1, "R2");
        send_byte(8'd2, 0, "R8");
        send_byte(8'd1, 0, "R8");
        send_byte(8'h80, 0, "R8");
        bus_stop();
        chk("R8", "out2_sel48 unchanged", int'(out2_sel48), 0);

        // R9 bad counts
        bus_start();
        send_byte(8'hD4, 1, "R2");
        send_byte(8'd0, 1, "R9");
        send_byte(8'd0, 0, "R9");
        bus_stop();
        bus_start();
        send_byte(8'hD4, 1, "R2");
        send_byte(8'd0, 1, "R9");
        send_byte(8'd3, 0, "R9");
        send_byte(8'h00, 0, "R9");
        bus_stop();
        bus_start();
        send_byte(8'hD4, 1, "R2");
        send_byte(8'd1, 1, "R9");
        send_byte(8'd2, 0, "R9");
        send_byte(8'h80, 0, "R9");
        bus_stop();
        chk("R9", "pll1_en unchanged", int'(pll1_en), 1);
        chk("R9", "pll2_en unchanged", int'(pll2_en), 1);
        chk("R9", "out2_sel48 unchanged", int'(out2_sel48), 0);
        read_regs(8'd0, 8'h57, 8'h2C, "R9");

        // R10 surplus data byte
        write_hdr(8'd1, 8'd1);
        send_byte(8'h81, 1, "R3");
        send_byte(8'h00, 0, "R10");
        bus_stop();
        chk("R10", "out2_sel48 keeps 0x81 bit7", int'(out2_sel48), 1);
        read_regs(8'd0, 8'h57, 8'h81, "R10");

        // R12 spikes on both lines during the data byte
        write_hdr(8'd1, 8'd1);
        send_byte(8'h05, 1, "R12", 1);
        bus_stop();
        chk("R12", "out2_sel48 after filtered write", int'(out2_sel48), 0);
        read_regs(8'd1, 8'h57, 8'h05, "R12");

        chk("R13", "sda_oe moves while SCL high", oe_viol, 0);
        chk("R6", "scoreboard drained", sb_q.size(), 0);
        report();
    end
endmodule